// File: doc/BRIEF.md
# Nibble-Serial Register Command Decoder

This block turns a stream of 8-bit command bytes from a host link into accesses on a small internal register file. Each byte holds an operation code in its upper bits and a 4-bit payload in its low nibble. The host builds the 8-bit register address from two nibble loads and the write data from two nibble loads. The command that carries the upper data nibble also commits the write. A read command places the byte at the current address on a valid/ready output stream. A read may also step the low address nibble, and that step wraps inside the current 16-register page.

The register file holds a read-only identification register, a scratch test register and a parameterised bank of generic read/write registers. Any other address reads as zero and ignores writes. The command input has a valid/ready handshake. It is held off while a read result waits on a stalled output, so no result is lost.

Top module: `nsr_cmd_decoder`

## Requirements
- R1: Command field layout: bits [7:5] select the operation, bit 4 is the step modifier, bits [3:0] are the payload. Encodings: 000 address-low, 001 address-high, 010 data-low, 011 data-high-and-write, 100 read. The step modifier has no effect on any operation other than read (for example 0x15 acts as address-low with payload 5).
- R2: Address-low replaces bits [3:0] of the address and address-high replaces bits [7:4]. Each keeps the other nibble.
- R3: Data-low stages a nibble. Data-high-and-write writes {payload, staged nibble} to the current address in the same cycle and leaves the address unchanged.
- R4: An accepted read command (opcode 100) presents the byte at the current address on rsp_data with rsp_valid high from the next cycle. Other commands produce no output byte.
- R5: A read with bit 4 set increments address bits [3:0] after the read, wrapping 0xF to 0x0 while bits [7:4] stay unchanged. A read with bit 4 clear leaves the address alone.
- R6: Repeated data-low/data-high-and-write pairs with no address command between them all write the same register, and the last byte written is kept. A burst of at least 32 pairs is accepted.
- R7: The test register (default address 0x01) reads back the last byte written, including 0x55 and 0xAA.
- R8: The identification register (default address 0x00) always reads ID_VALUE (default 0xA5). Writes to it have no effect.
- R9: Opcodes 101, 110 and 111 are accepted and change neither the address nor the staged data nibble.
- R10: After reset the address is 0x00, the staged nibble is 0, the test register and all generic registers (default 16 at 0x10 to 0x1F) are 0x00, rsp_valid is low and cmd_ready is high.
- R11: While rsp_valid is high and rsp_ready is low, cmd_ready is low and rsp_data holds steady. A waiting command is taken in the cycle the output is drained.
- R12: Addresses outside the identification, test and generic registers read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command byte offered |
| cmd_data | input | 8 | Command byte |
| cmd_ready | output | 1 | Command byte taken when high together with cmd_valid |
| rsp_valid | output | 1 | Read result present |
| rsp_data | output | 8 | Read result byte |
| rsp_ready | input | 1 | Consumer takes the read result |

## Verification
Two things can happen in one cycle: the output slot hands its byte to the consumer, and the next command, often another read, is accepted. The bench stalls the output with a read result waiting and holds a second command on the input. It checks that cmd_ready stays low and that the result byte does not change. It then raises rsp_ready while the second command is still offered. The next sample must show the second command's effect: a fresh result byte, or an address change seen in a later read. None of the first result may be lost or repeated.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

  typedef enum logic [2:0] {
    OP_ADDR_LO = 3'd0,
    OP_ADDR_HI = 3'd1,
    OP_DATA_LO = 3'd2,
    OP_DATA_WR = 3'd3,
    OP_READ    = 3'd4
  } nsr_op_e;

  typedef struct packed {
    logic       ld_addr_lo;
    logic       ld_addr_hi;
    logic       ld_data_lo;
    logic       commit;
    logic       rd;
    logic       step;
    logic [3:0] nib;
  } nsr_dec_t;

endpackage

// File: rtl/nsr_cmd_parse.sv
module nsr_cmd_parse
  import nsr_pkg::*;
(
  input  logic       fire,
  input  logic [7:0] cmd_byte,
  output nsr_dec_t   dec
);

  logic [2:0] opc;

  assign opc = cmd_byte[7:5];

  always_comb begin
    dec            = '0;
    dec.nib        = cmd_byte[3:0];
    if (fire) begin
      unique case (opc)
        OP_ADDR_LO: dec.ld_addr_lo = 1'b1;
        OP_ADDR_HI: dec.ld_addr_hi = 1'b1;
        OP_DATA_LO: dec.ld_data_lo = 1'b1;
        OP_DATA_WR: dec.commit     = 1'b1;
        OP_READ: begin
          dec.rd   = 1'b1;
          dec.step = cmd_byte[4];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nsr_addr_stage.sv
module nsr_addr_stage
  import nsr_pkg::*;
#(
  parameter int AW = 8,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  nsr_dec_t      dec,
  output logic [AW-1:0] addr,
  output logic [NW-1:0] data_lo
);

  logic [AW-1:0] addr_nxt;
  logic [NW-1:0] data_lo_nxt;
  logic          addr_en;
  logic          data_en;

  assign addr_en = dec.ld_addr_lo | dec.ld_addr_hi | (dec.rd & dec.step);
  assign data_en = dec.ld_data_lo;

  always_comb begin
    addr_nxt    = addr;
    data_lo_nxt = data_lo;
    if (dec.ld_addr_lo) addr_nxt[NW-1:0]  = dec.nib;
    if (dec.ld_addr_hi) addr_nxt[AW-1:NW] = dec.nib;
    if (dec.rd && dec.step) addr_nxt[NW-1:0] = addr[NW-1:0] + 1'b1;
    if (dec.ld_data_lo) data_lo_nxt = dec.nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      data_lo <= '0;
    end else begin
      if (addr_en) addr    <= addr_nxt;
      if (data_en) data_lo <= data_lo_nxt;
    end
  end

endmodule

// File: rtl/nsr_regbank.sv
module nsr_regbank #(
  parameter int         AW        = 8,
  parameter int         DW        = 8,
  parameter logic [7:0] ID_VALUE  = 8'hA5,
  parameter logic [7:0] ID_ADDR   = 8'h00,
  parameter logic [7:0] TEST_ADDR = 8'h01,
  parameter logic [7:0] GEN_BASE  = 8'h10,
  parameter int         GEN_COUNT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] test_q;
  logic [DW-1:0] gen_q   [GEN_COUNT];
  logic [GEN_COUNT-1:0] gen_hit;
  logic          test_hit;

  assign test_hit = (addr == TEST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_q <= '0;
    else if (wr_en && test_hit) test_q <= wr_data;
  end

  for (genvar g = 0; g < GEN_COUNT; g++) begin : g_gen
    localparam logic [AW-1:0] GA = AW'(GEN_BASE + g);
    assign gen_hit[g] = (addr == GA);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gen_q[g] <= '0;
      else if (wr_en && gen_hit[g]) gen_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ID_ADDR) rd_data = ID_VALUE;
    else if (test_hit) rd_data = test_q;
    else begin
      for (int i = 0; i < GEN_COUNT; i++) begin
        if (gen_hit[i]) rd_data = gen_q[i];
      end
    end
  end

endmodule

// File: rtl/nsr_rsp_slot.sv
module nsr_rsp_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          can_accept
);

  logic valid_nxt;

  assign can_accept = ~rsp_valid | rsp_ready;
  assign valid_nxt  = load | (rsp_valid & ~rsp_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= valid_nxt;
      if (load) rsp_data <= load_data;
    end
  end

endmodule

// File: rtl/nsr_cmd_decoder.sv
module nsr_cmd_decoder
  import nsr_pkg::*;
#(
  parameter logic [7:0] ID_VALUE  = 8'hA5,
  parameter logic [7:0] ID_ADDR   = 8'h00,
  parameter logic [7:0] TEST_ADDR = 8'h01,
  parameter logic [7:0] GEN_BASE  = 8'h10,
  parameter int         GEN_COUNT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_data,
  output logic       cmd_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  input  logic       rsp_ready
);

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NW = AW / 2;

  logic          rst_meta_n;
  logic          rst_sync_n;
  logic          fire;
  logic          can_accept;
  nsr_dec_t      dec;
  logic [AW-1:0] cur_addr;
  logic [NW-1:0] data_lo;
  logic [DW-1:0] rd_byte;
  logic [DW-1:0] wr_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign cmd_ready = rst_sync_n & can_accept;
  assign fire      = cmd_valid & cmd_ready;
  assign wr_byte   = {dec.nib, data_lo};

  nsr_cmd_parse u_parse (
    .fire     (fire),
    .cmd_byte (cmd_data),
    .dec      (dec)
  );

  nsr_addr_stage #(.AW(AW), .NW(NW)) u_stage (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .dec     (dec),
    .addr    (cur_addr),
    .data_lo (data_lo)
  );

  nsr_regbank #(
    .AW(AW), .DW(DW), .ID_VALUE(ID_VALUE), .ID_ADDR(ID_ADDR),
    .TEST_ADDR(TEST_ADDR), .GEN_BASE(GEN_BASE), .GEN_COUNT(GEN_COUNT)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (dec.commit),
    .addr    (cur_addr),
    .wr_data (wr_byte),
    .rd_data (rd_byte)
  );

  nsr_rsp_slot #(.DW(DW)) u_slot (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (dec.rd),
    .load_data  (rd_byte),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .can_accept (can_accept)
  );

endmodule

// File: rtl/nsr_cmd_decoder_chk.sv
module nsr_cmd_decoder_chk #(
  parameter logic [7:0] ID_VALUE = 8'hA5,
  parameter logic [7:0] ID_ADDR  = 8'h00
) (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_data,
  input logic       cmd_ready,
  input logic       rsp_valid,
  input logic [7:0] rsp_data,
  input logic       rsp_ready,
  input logic [7:0] cur_addr,
  input logic [3:0] data_lo
);

  logic acc;
  assign acc = cmd_valid & cmd_ready;

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready); // R11

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R11

  AST_READ_GIVES_BYTE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc && cmd_data[7:5] == 3'd4) |=> rsp_valid); // R4

  AST_NONREAD_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc && cmd_data[7:5] != 3'd4) |=> !rsp_valid); // R4

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc && cmd_data[7:4] == 4'h9) |=>
      (cur_addr[7:4] == $past(cur_addr[7:4]) &&
       cur_addr[3:0] == 4'($past(cur_addr[3:0]) + 4'd1))); // R5

  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc && cmd_data[7:5] == 3'd4 && cur_addr == ID_ADDR) |=> (rsp_data == ID_VALUE)); // R8

  AST_IGNORED_OP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc && cmd_data[7:5] >= 3'd5) |=> ($stable(cur_addr) && $stable(data_lo))); // R9

endmodule

bind nsr_cmd_decoder nsr_cmd_decoder_chk #(.ID_VALUE(ID_VALUE), .ID_ADDR(ID_ADDR)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cmd_valid  (cmd_valid),
  .cmd_data   (cmd_data),
  .cmd_ready  (cmd_ready),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .rsp_ready  (rsp_ready),
  .cur_addr   (cur_addr),
  .data_lo    (data_lo)
);

// File: tb/nsr_cmd_decoder_bench.sv
`timescale 1ns/1ps
module nsr_cmd_decoder_bench;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_data;
  logic       cmd_ready;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       rsp_ready;

  int n_chk;
  int n_bad;
  logic done;

  nsr_cmd_decoder u_nsr_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_ready(rsp_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: [20:17] requirement number, [16] read-and-check, [15:8] command, [7:0] expected
  localparam int NV = 48;
  localparam logic [20:0] VEC [NV] = '{
    {4'd8,  1'b1, 8'h80, 8'hA5},  // R8 ID at reset address 0x00
    {4'd2,  1'b0, 8'h01, 8'h00},  // R2 addr lo 1
    {4'd2,  1'b0, 8'h20, 8'h00},
    {4'd10, 1'b1, 8'h80, 8'h00},  // R10 test reg cleared
    {4'd7,  1'b0, 8'h45, 8'h00},
    {4'd7,  1'b0, 8'h65, 8'h00},
    {4'd7,  1'b1, 8'h80, 8'h55},  // R7
    {4'd7,  1'b0, 8'h4A, 8'h00},
    {4'd7,  1'b0, 8'h6A, 8'h00},
    {4'd7,  1'b1, 8'h80, 8'hAA},  // R7
    {4'd2,  1'b0, 8'h03, 8'h00},
    {4'd2,  1'b0, 8'h21, 8'h00},  // addr 0x13
    {4'd10, 1'b1, 8'h80, 8'h00},  // R10 generic cleared
    {4'd3,  1'b0, 8'h44, 8'h00},
    {4'd3,  1'b0, 8'h63, 8'h00},
    {4'd3,  1'b1, 8'h80, 8'h34},  // R3
    {4'd2,  1'b0, 8'h04, 8'h00},  // addr 0x14, high kept
    {4'd2,  1'b1, 8'h80, 8'h00},  // R2
    {4'd12, 1'b0, 8'h20, 8'h00},  // addr 0x04
    {4'd12, 1'b0, 8'h47, 8'h00},
    {4'd12, 1'b0, 8'h67, 8'h00},
    {4'd12, 1'b1, 8'h80, 8'h00},  // R12
    {4'd8,  1'b0, 8'h00, 8'h00},  // addr 0x00
    {4'd8,  1'b0, 8'h41, 8'h00},
    {4'd8,  1'b0, 8'h61, 8'h00},
    {4'd8,  1'b1, 8'h80, 8'hA5},  // R8 write ignored
    {4'd5,  1'b0, 8'h0F, 8'h00},
    {4'd5,  1'b0, 8'h21, 8'h00},  // addr 0x1F
    {4'd5,  1'b0, 8'h42, 8'h00},
    {4'd5,  1'b0, 8'h69, 8'h00},  // 0x92 at 0x1F
    {4'd5,  1'b0, 8'h00, 8'h00},  // addr 0x10
    {4'd5,  1'b0, 8'h4C, 8'h00},
    {4'd5,  1'b0, 8'h6B, 8'h00},  // 0xBC at 0x10
    {4'd5,  1'b0, 8'h0F, 8'h00},  // addr 0x1F
    {4'd5,  1'b1, 8'h90, 8'h92},  // R5 read and step
    {4'd5,  1'b1, 8'h80, 8'hBC},  // R5 wrapped to 0x10
    {4'd5,  1'b1, 8'h90, 8'hBC},
    {4'd5,  1'b1, 8'h80, 8'h00},  // R5 now 0x11
    {4'd9,  1'b0, 8'h02, 8'h00},  // addr 0x12
    {4'd9,  1'b0, 8'h43, 8'h00},
    {4'd9,  1'b0, 8'hA7, 8'h00},
    {4'd9,  1'b0, 8'hC9, 8'h00},
    {4'd9,  1'b0, 8'hEF, 8'h00},
    {4'd9,  1'b0, 8'h66, 8'h00},
    {4'd9,  1'b1, 8'h80, 8'h63},  // R9 addr and staged nibble kept
    {4'd1,  1'b0, 8'h3B, 8'h00},  // R1 modifier on addr-high: still addr-high 0xB
    {4'd1,  1'b0, 8'h15, 8'h00},  // R1 modifier on addr-low: addr 0xB5
    {4'd1,  1'b1, 8'h80, 8'h00}   // R1 unmapped 0xB5
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = b;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_chk(input logic [7:0] b, input logic [7:0] exp, input string tag);
    send(b);
    idle();
    chk({tag, " valid"}, {7'd0, rsp_valid}, 8'd1);
    chk(tag, rsp_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = 8'h00; rsp_ready = 1'b1;
    do_reset();
    // R10 reset outputs
    chk("R10 rsp_valid", {7'd0, rsp_valid}, 8'd0);
    chk("R10 cmd_ready", {7'd0, cmd_ready}, 8'd1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) begin
        send(VEC[i][15:8]);
        idle();
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_data !== VEC[i][7:0]) begin
          n_bad++;
          $display("FAIL R%0d vector %0d actual=%02h valid=%0b expected=%02h",
                   VEC[i][20:17], i, rsp_data, rsp_valid, VEC[i][7:0]);
        end
      end else begin
        send(VEC[i][15:8]);
        idle();
        n_chk++;
        if (rsp_valid !== 1'b0) begin
          n_bad++;
          $display("FAIL R4 vector %0d spurious output actual=1 expected=0", i);
        end
      end
    end

    // R6: burst of 32 writes to 0x16, last wins
    send(8'h06); send(8'h21);
    for (int k = 0; k < 32; k++) begin
      logic [7:0] v;
      v = 8'(k * 7 + 1);
      send({4'h4, v[3:0]});
      send({4'h6, v[7:4]});
    end
    read_chk(8'h80, 8'(31 * 7 + 1), "R6 burst last byte");
    send(8'h07);
    read_chk(8'h80, 8'h00, "R6 neighbour untouched");

    // R11: stall with a result waiting, second command held
    send(8'h03);                       // addr 0x13 (holds 0x34)
    idle();
    rsp_ready = 1'b0;
    send(8'h80);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = 8'h02;                 // addr-low 2, must wait
    for (int k = 0; k < 3; k++) begin
      chk("R11 cmd_ready low", {7'd0, cmd_ready}, 8'd0);
      chk("R11 data held", rsp_data, 8'h34);
      @(negedge clk);
    end
    rsp_ready = 1'b1;                  // drain and accept in one cycle
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 drained", {7'd0, rsp_valid}, 8'd0);
    read_chk(8'h80, 8'h63, "R11 held command applied");

    // R11: drain and accept a stepping read in the same cycle
    @(negedge clk);
    rsp_ready = 1'b0;
    send(8'h80);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = 8'h90;
    chk("R11 first result", rsp_data, 8'h63);
    rsp_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 second valid", {7'd0, rsp_valid}, 8'd1);
    chk("R11 second result", rsp_data, 8'h63);
    read_chk(8'h80, 8'h34, "R5 step after overlapped read");

    // R10: reset mid-run clears registers and address
    do_reset();
    read_chk(8'h80, 8'hA5, "R10 address back to 0");
    send(8'h03); send(8'h21);
    read_chk(8'h80, 8'h00, "R10 generic cleared again");
    send(8'h01); send(8'h20);
    read_chk(8'h80, 8'h00, "R10 test cleared again");
    send(8'h62);                       // staged nibble must be 0
    read_chk(8'h80, 8'h20, "R10 staged nibble zero");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule